// File: doc/BRIEF.md
# Horizontal CRT Timing Generator

This block produces the horizontal timing of each scan line for a raster display controller. A character-clock counter runs across the line. From the count and a set of programmed fields it derives display enable, horizontal blank, horizontal sync, a one-clock end-of-line strobe for the vertical timing logic, and the running count.

The line length field is biased: the programmed value is five less than the number of character clocks per line. Display end is one less than the number of active characters. Blank and sync are set/reset flags. Each is set by a full-width match on its start value. It is cleared by a match on only the low bits of the counter: 7 bits for blank and 6 bits for sync. Software therefore programs the end as start plus width, truncated to that many bits.

Display enable and sync each pass through their own delay line. A 2-bit field selects a delay of 0 to 3 character clocks. A sync-enable control forces sync low without touching any other state. All fields arrive already assembled and are sampled on every clock.

Top module: `hcrt_htiming`

## Requirements
- R1: `hcount` is 0 after reset. On each clock it advances by one. In the clock after it shows a value at or above `cfg_total`+4, it returns to 0. A line therefore lasts `cfg_total`+5 clocks.
- R2: `eol` is 1 for exactly the clock in which `hcount` shows 0 after a wrap, and 0 otherwise.
- R3: With display skew 0, `hde` in a clock equals (`hcount` <= `cfg_disp_end`) evaluated on the count of the previous clock.
- R4: `hblank` becomes 1 in the clock after `hcount` equals the full 9-bit `cfg_blank_start` while `hblank` is 0.
- R5: While `hblank` is 1, it clears in the clock after `hcount[6:0]` equals `cfg_blank_end`. While `hblank` is 0, a match on `cfg_blank_end` has no effect.
- R6: An internal sync flag sets on a full 9-bit match of `hcount` with `cfg_sync_start`. While set, it clears on a match of `hcount[5:0]` with `cfg_sync_end`. With sync skew 0 and sync enabled, `hsync` follows this flag with the same one-clock latency as `hblank`.
- R7: `cfg_de_skew` (value n, 0 to 3) delays `hde` by n further character clocks beyond the R3 timing.
- R8: `cfg_hs_skew` (value n, 0 to 3) delays `hsync` by n further character clocks. It is independent of `cfg_de_skew`.
- R9: When `sync_en` is 0 in a clock, `hsync` is 0 in the next clock. The counter, blank and the sync flag keep running, so sync resumes on its normal schedule when the control returns to 1.
- R10: A synchronous active-high `rst` clears the counter, flags and delay lines. During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_en | input | 1 | 0 holds hsync inactive |
| cfg_total | input | 9 | Clocks per line minus 5 |
| cfg_disp_end | input | 9 | Active characters minus 1 |
| cfg_blank_start | input | 9 | Count at which blank sets |
| cfg_blank_end | input | 7 | Low 7 count bits at which blank clears |
| cfg_sync_start | input | 9 | Count at which sync sets |
| cfg_sync_end | input | 6 | Low 6 count bits at which sync clears |
| cfg_de_skew | input | 2 | Display enable delay, 0 to 3 clocks |
| cfg_hs_skew | input | 2 | Sync delay, 0 to 3 clocks |
| hde | output | 1 | Display enable |
| hblank | output | 1 | Horizontal blank |
| hsync | output | 1 | Horizontal sync, active high |
| eol | output | 1 | End-of-line strobe |
| hcount | output | 10 | Character clock count |

## Verification
The bench goes after these corner cases and the failures a wrong design would show:
- **Shortest line (programmed total 0).** An off-by-one bias would give four or six clocks per line instead of five.
- **Blank end value reached before blank start.** A design that checked the end compare while blank is clear would be harmless in that case, but one that matched the full width would never end blank when start plus width crosses a 128 boundary.
- **Sync end after a 64-count wrap.** The same full-width mistake would leave sync stuck high.
- **All sixteen combinations of the two skews.** A swapped or shared delay line would shift the wrong output.
- **Sync enable dropped in mid-pulse and restored.** A design that cleared the sync flag would lose the rest of the pulse after re-enable.
- **A shorter total programmed while the count is already past it.** An equality-only wrap would let the count run on to its full range.

// File: rtl/hcrt_pkg.sv
package hcrt_pkg;
  // Bias between the programmed line total and clocks per line.
  localparam int HCRT_TOTAL_BIAS = 5;
  // Largest programmable skew in character clocks.
  localparam int HCRT_MAX_SKEW   = 3;
  // Programmed field widths.
  localparam int HCRT_TOT_W      = 9;
  localparam int HCRT_BEND_W     = 7;
  localparam int HCRT_SEND_W     = 6;
endpackage

// File: rtl/hcrt_char_counter.sv
module hcrt_char_counter #(
  parameter int TOT_W = 9,
  parameter int BIAS  = 5,
  parameter int CNT_W = TOT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TOT_W-1:0] total,
  output logic [CNT_W-1:0] cnt_q,
  output logic             eol_q
);
  localparam logic [CNT_W-1:0] LAST_OFS = CNT_W'(BIAS - 1);

  logic [CNT_W-1:0] last_pos;
  logic             wrap;

  // Last count of the line; at or beyond it the counter restarts.
  assign last_pos = CNT_W'(total) + LAST_OFS;
  assign wrap     = (cnt_q >= last_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      eol_q <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
      eol_q <= wrap;
    end
  end
endmodule

// File: rtl/hcrt_window_flag.sv
module hcrt_window_flag #(
  parameter int CNT_W   = 10,
  parameter int START_W = 9,
  parameter int END_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [START_W-1:0] start_val,
  input  logic [END_W-1:0]   stop_low,
  output logic               flag_nxt
);
  logic flag_q;
  logic start_hit;
  logic stop_hit;

  assign start_hit = (cnt == CNT_W'(start_val));
  // Only the low END_W bits take part in the end compare.
  assign stop_hit  = (cnt[END_W-1:0] == stop_low);

  // The end compare is looked at only while the flag is set.
  assign flag_nxt  = flag_q ? !stop_hit : start_hit;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_nxt;
  end
endmodule

// File: rtl/hcrt_skew_line.sv
module hcrt_skew_line #(
  parameter int MAX_SKEW = 3,
  parameter int SEL_W    = $clog2(MAX_SKEW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  input  logic             gate,
  output logic             dout_q
);
  logic [MAX_SKEW-1:0] stage;
  logic                tap;

  genvar g;
  generate
    for (g = 0; g < MAX_SKEW; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= 1'b0;
          else     stage[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= 1'b0;
          else     stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  // Tap 0 is the live input, tap k is k clocks old.
  always_comb begin
    tap = din;
    for (int k = 1; k <= MAX_SKEW; k++) begin
      if (sel == SEL_W'(k)) tap = stage[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dout_q <= 1'b0;
    else     dout_q <= gate & tap;
  end
endmodule

// File: rtl/hcrt_htiming.sv
module hcrt_htiming
  import hcrt_pkg::*;
#(
  parameter int TOT_W    = HCRT_TOT_W,
  parameter int BEND_W   = HCRT_BEND_W,
  parameter int SEND_W   = HCRT_SEND_W,
  parameter int BIAS     = HCRT_TOTAL_BIAS,
  parameter int MAX_SKEW = HCRT_MAX_SKEW,
  parameter int SKW_W    = $clog2(MAX_SKEW + 1),
  parameter int CNT_W    = TOT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_en,
  input  logic [TOT_W-1:0]  cfg_total,
  input  logic [TOT_W-1:0]  cfg_disp_end,
  input  logic [TOT_W-1:0]  cfg_blank_start,
  input  logic [BEND_W-1:0] cfg_blank_end,
  input  logic [TOT_W-1:0]  cfg_sync_start,
  input  logic [SEND_W-1:0] cfg_sync_end,
  input  logic [SKW_W-1:0]  cfg_de_skew,
  input  logic [SKW_W-1:0]  cfg_hs_skew,
  output logic              hde,
  output logic              hblank,
  output logic              hsync,
  output logic              eol,
  output logic [CNT_W-1:0]  hcount
);
  logic [CNT_W-1:0] cnt;
  logic             de_raw;
  logic             blank_nxt;
  logic             sync_nxt;
  logic             blank_q;

  hcrt_char_counter #(.TOT_W(TOT_W), .BIAS(BIAS), .CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .total (cfg_total),
    .cnt_q (cnt),
    .eol_q (eol)
  );

  assign de_raw = (cnt <= CNT_W'(cfg_disp_end));

  hcrt_window_flag #(.CNT_W(CNT_W), .START_W(TOT_W), .END_W(BEND_W)) u_blank (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt),
    .start_val (cfg_blank_start),
    .stop_low  (cfg_blank_end),
    .flag_nxt  (blank_nxt)
  );

  hcrt_window_flag #(.CNT_W(CNT_W), .START_W(TOT_W), .END_W(SEND_W)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt),
    .start_val (cfg_sync_start),
    .stop_low  (cfg_sync_end),
    .flag_nxt  (sync_nxt)
  );

  hcrt_skew_line #(.MAX_SKEW(MAX_SKEW), .SEL_W(SKW_W)) u_de_dly (
    .clk    (clk),
    .rst    (rst),
    .din    (de_raw),
    .sel    (cfg_de_skew),
    .gate   (1'b1),
    .dout_q (hde)
  );

  // Sync enable gates only the output; the flag keeps its schedule.
  hcrt_skew_line #(.MAX_SKEW(MAX_SKEW), .SEL_W(SKW_W)) u_hs_dly (
    .clk    (clk),
    .rst    (rst),
    .din    (sync_nxt),
    .sel    (cfg_hs_skew),
    .gate   (sync_en),
    .dout_q (hsync)
  );

  always_ff @(posedge clk) begin
    if (rst) blank_q <= 1'b0;
    else     blank_q <= blank_nxt;
  end

  assign hblank = blank_q;
  assign hcount = cnt;
endmodule

// File: rtl/hcrt_htiming_chk.sv
module hcrt_htiming_chk #(
  parameter int TOT_W  = 9,
  parameter int BEND_W = 7,
  parameter int SEND_W = 6,
  parameter int BIAS   = 5,
  parameter int SKW_W  = 2,
  parameter int CNT_W  = TOT_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_en,
  input logic [TOT_W-1:0]  cfg_total,
  input logic [TOT_W-1:0]  cfg_disp_end,
  input logic [TOT_W-1:0]  cfg_blank_start,
  input logic [BEND_W-1:0] cfg_blank_end,
  input logic [TOT_W-1:0]  cfg_sync_start,
  input logic [SEND_W-1:0] cfg_sync_end,
  input logic [SKW_W-1:0]  cfg_de_skew,
  input logic [SKW_W-1:0]  cfg_hs_skew,
  input logic              hde,
  input logic              hblank,
  input logic              hsync,
  input logic              eol,
  input logic [CNT_W-1:0]  hcount
);
  logic [CNT_W-1:0] line_last;
  assign line_last = CNT_W'(cfg_total) + CNT_W'(BIAS - 1);

  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (hcount >= line_last) |=> (hcount == '0));

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (hcount < line_last) |=> (hcount == $past(hcount) + CNT_W'(1)));

  assert_eol_zero_R2: assert property (@(posedge clk) disable iff (rst)
    eol |-> (hcount == '0));

  assert_de_noskew_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_de_skew == '0) |=> (hde == $past(hcount <= CNT_W'(cfg_disp_end))));

  assert_blank_set_R4: assert property (@(posedge clk) disable iff (rst)
    (!hblank && hcount == CNT_W'(cfg_blank_start)) |=> hblank);

  assert_blank_clr_R5: assert property (@(posedge clk) disable iff (rst)
    (hblank && hcount[BEND_W-1:0] == cfg_blank_end) |=> !hblank);

  assert_sync_clr_R6: assert property (@(posedge clk) disable iff (rst)
    (hsync && sync_en && cfg_hs_skew == '0 && $past(cfg_hs_skew) == '0 &&
     hcount[SEND_W-1:0] == cfg_sync_end) |=> !hsync);

  assert_sync_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !sync_en |=> !hsync);
endmodule

bind hcrt_htiming hcrt_htiming_chk #(
  .TOT_W(TOT_W), .BEND_W(BEND_W), .SEND_W(SEND_W), .BIAS(BIAS),
  .SKW_W(SKW_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .sync_en(sync_en), .cfg_total(cfg_total),
  .cfg_disp_end(cfg_disp_end), .cfg_blank_start(cfg_blank_start),
  .cfg_blank_end(cfg_blank_end), .cfg_sync_start(cfg_sync_start),
  .cfg_sync_end(cfg_sync_end), .cfg_de_skew(cfg_de_skew),
  .cfg_hs_skew(cfg_hs_skew), .hde(hde), .hblank(hblank), .hsync(hsync),
  .eol(eol), .hcount(hcount)
);

// File: tb/sim_hcrt_htiming.sv
`timescale 1ns/1ps
module sim_hcrt_htiming;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sen = 1'b1;
  logic [8:0] total = 9'd10, dend = 9'd5, bstart = 9'd7, sstart = 9'd8;
  logic [6:0] bend = 7'd12;
  logic [5:0] send = 6'd11;
  logic [1:0] dsk = 2'd0, hsk = 2'd0;
  logic       hde, hblank, hsync, eol;
  logic [9:0] hcount;

  int checks = 0;
  int errors = 0;

  // Reference state
  int   m_cnt = 0;
  logic m_blk = 1'b0, m_sf = 1'b0;
  logic [3:0] dh = '0, sh = '0;

  always #2 clk = ~clk;

  hcrt_htiming u0 (
    .clk(clk), .rst(rst), .sync_en(sen), .cfg_total(total),
    .cfg_disp_end(dend), .cfg_blank_start(bstart), .cfg_blank_end(bend),
    .cfg_sync_start(sstart), .cfg_sync_end(send), .cfg_de_skew(dsk),
    .cfg_hs_skew(hsk), .hde(hde), .hblank(hblank), .hsync(hsync),
    .eol(eol), .hcount(hcount)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // One clock: advance reference with the inputs held across the edge, compare.
  task automatic tick();
    int   prev, last;
    logic de_raw, bn, sn, e_hde, e_hs, e_eol;
    @(posedge clk);
    @(negedge clk);
    if (rst) begin
      m_cnt = 0; m_blk = 0; m_sf = 0; dh = '0; sh = '0;
      chk("R10 hcount", int'(hcount), 0);
      chk("R10 hde", int'(hde), 0);
      chk("R10 hblank", int'(hblank), 0);
      chk("R10 hsync", int'(hsync), 0);
      chk("R10 eol", int'(eol), 0);
    end else begin
      prev   = m_cnt;
      last   = int'(total) + 4;
      de_raw = (prev <= int'(dend));
      bn = m_blk ? ((prev % 128) != int'(bend)) : (prev == int'(bstart));
      sn = m_sf  ? ((prev % 64)  != int'(send)) : (prev == int'(sstart));
      dh = {dh[2:0], de_raw};
      sh = {sh[2:0], sn};
      e_hde = dh[dsk];
      e_hs  = sen & sh[hsk];
      e_eol = (prev >= last);
      m_blk = bn; m_sf = sn;
      m_cnt = (prev >= last) ? 0 : prev + 1;
      chk("R1 hcount", int'(hcount), m_cnt);
      chk("R2 eol", int'(eol), int'(e_eol));
      chk("R3 R7 hde", int'(hde), int'(e_hde));
      chk("R4 R5 hblank", int'(hblank), int'(bn));
      chk("R6 R8 R9 hsync", int'(hsync), int'(e_hs));
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int seed_dummy;
    int len;
    seed_dummy = $urandom(32'h5eed);
    // R10: reset state
    run(3);
    rst = 1'b0;
    // R1 R2: shortest line, five clocks
    total = 9'd0; dend = 9'd2; bstart = 9'd3; bend = 7'd1;
    sstart = 9'd2; send = 6'd4;
    run(22);
    // R5: end value met before start while blank clear is ignored
    total = 9'd20; dend = 9'd15; bstart = 9'd15; bend = 7'd5;
    sstart = 9'd16; send = 6'd22;
    run(60);
    // R7 R8: every skew pairing
    for (int d = 0; d < 4; d++) begin
      for (int h = 0; h < 4; h++) begin
        dsk = 2'(d); hsk = 2'(h);
        total = 9'd9; dend = 9'd6; bstart = 9'd7; bend = 7'd12;
        sstart = 9'd8; send = 6'd11;
        run(30);
      end
    end
    // R9: drop sync enable inside the pulse, then restore
    hsk = 2'd1;
    run(9);
    sen = 1'b0; run(20);
    sen = 1'b1; run(30);
    // R1: shorter total while the count is already beyond it
    total = 9'd40; run(40);
    total = 9'd3; run(20);
    // R10: reset in mid-line
    rst = 1'b1; run(2); rst = 1'b0;
    // R5 R6: widest line, ends crossing the partial-compare wrap
    total = 9'd511; dend = 9'd479; bstart = 9'd500; bend = 7'((500 + 20) % 128);
    sstart = 9'd490; send = 6'((490 + 40) % 64); dsk = 2'd2; hsk = 2'd3;
    run(1100);
    // Random configurations
    for (int c = 0; c < 60; c++) begin
      total  = 9'($urandom % 60);
      len    = int'(total) + 5;
      dend   = 9'($urandom % len);
      bstart = 9'($urandom % len);
      bend   = 7'((int'(bstart) + 1 + int'($urandom % len)) % 128);
      sstart = 9'($urandom % len);
      send   = 6'((int'(sstart) + 1 + int'($urandom % 8)) % 64);
      dsk    = 2'($urandom % 4);
      hsk    = 2'($urandom % 4);
      for (int k = 0; k < 2 * len + 10; k++) begin
        sen = (($urandom % 8) != 0);
        tick();
      end
    end
    summary();
    $finish;
  end
endmodule